// File: doc/BRIEF.md
# Paged Shared Video Memory Address Generator

This block forms the DRAM address for a 128 KB memory that the CPU and the display controller share. The memory is split into four 32 KB pages. A CPU byte address either lands in a fixed 32 KB display window or in the system-RAM range. A display-controller word address is widened with page bits from a control register. The chosen word address is then presented to the DRAM pins as an 8-bit row followed by an 8-bit column.

The DRAM is two 64K x 8 banks. The display reads them together as 64K x 16. The CPU sees them as 128K x 8, and its byte address bit 0 picks the bank. An 8-bit page/control register holds the CPU window page and the display page. Its top two bits change how addresses are formed for high-resolution graphics. Graphics modes that use only 16 KB need no register setting, because the display page then simply wraps inside one page.

Top module: `vmag_top`

## Requirements
- R1: While `rst_n` is low, a rising clock edge clears the page register, `dram_addr`, `dram_req` and `dram_bank` to zero. After reset, both the window and the display use page 0.
- R2: A cycle with `reg_wr` high loads `reg_wdata` into the page register at the clock edge, and the new value affects addresses from the next cycle on. Without `reg_wr` the register holds its value. The fields are: bits [1:0] = CPU window page, bits [3:2] = display page, bit 6 = window-follows-display, bit 7 = wide display. Bits [5:4] have no effect.
- R3: A CPU address with bits [19:15] equal to 0x17 (0xB8000–0xBFFFF) is a window hit. Its physical byte address is {window page, cpu_addr[14:0]}.
- R4: A CPU address in 0x00000–0x1FFFF is a system hit. Its physical byte address is cpu_addr[16:0], whatever the register holds.
- R5: Any other CPU address leaves `cpu_hit` low. If `vid_cycle` is also low, `dram_req` is low in the next cycle.
- R6: With bit 7 clear, the display word address is {display page, vid_addr[13:0]}, and vid_addr[14] has no effect.
- R7: With bit 7 set, the display word address is {display page bit 1, vid_addr[14:0]}, so the display spans two pages.
- R8: With bit 6 set, the window uses the display page in place of bits [1:0].
- R9: For a CPU access, the DRAM word address is physical[16:1] and `dram_bank` is physical bit 0. For a display access, `dram_bank` is 0.
- R10: One cycle after the inputs, `dram_addr` shows word[7:0] (row) when `col_sel` was 0, and word[15:8] (column) when `col_sel` was 1.
- R11: When `vid_cycle` is high, the display word address drives the DRAM whatever the CPU address is, and `dram_req` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Page register write strobe |
| reg_wdata | input | 8 | Page register write data |
| cpu_addr | input | 20 | CPU byte address |
| vid_addr | input | 15 | Display-controller word address |
| vid_cycle | input | 1 | 1 = display owns this DRAM slot |
| col_sel | input | 1 | 0 = row phase, 1 = column phase (from access sequencer) |
| cpu_hit | output | 1 | CPU address decodes to window or system RAM (combinational) |
| dram_req | output | 1 | Registered DRAM access request |
| dram_addr | output | 8 | Registered multiplexed row/column address |
| dram_bank | output | 1 | Registered byte-bank select |

## Verification
The assertions assume a few things about the inputs. `col_sel` and `vid_cycle` are held for a whole cycle and change only between edges. Writes to the page register arrive as single-cycle strobes. The checks relate each registered output to the inputs of the cycle before, so they depend on the sequencer not changing inputs in the middle of a cycle. The bench drives every input on the falling edge and keeps it stable through the next rising edge. Its random CPU addresses are drawn from three separate pools (window, system, unmapped), so every decode outcome appears often.

// File: rtl/vmag_pkg.sv
// Shared types for the paged video memory address generator.
// Assumes a 2-bit page number and 32 KB (15-bit) pages.
package vmag_pkg;
    localparam int PAGE_W = 2;
    localparam int OFFS_W = 15;
    localparam int PHYS_W = PAGE_W + OFFS_W;

    // Page/control register layout; bit positions are software visible.
    typedef struct packed {
        logic              wide;        // bit 7: display spans two pages
        logic              win_follow;  // bit 6: window uses display page
        logic [1:0]        spare;       // bits 5:4: no effect
        logic [PAGE_W-1:0] vid_page;    // bits 3:2
        logic [PAGE_W-1:0] cpu_page;    // bits 1:0
    } page_reg_t;
endpackage

// File: rtl/vmag_page_reg.sv
// Page/control register: loads on a write strobe, clears on reset.
// Assumes the write strobe is one cycle wide and synchronous to clk.
module vmag_page_reg
    import vmag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  page_reg_t wdata,
    output page_reg_t q
);
    // Hold or load the register each clock.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/vmag_cpu_decode.sv
// CPU address decode: recognises the display window and the system-RAM
// range, and forms the 128 KB physical byte address.
// Assumes the window base is aligned to a page and the system base to 128 KB.
module vmag_cpu_decode
    import vmag_pkg::*;
#(
    parameter int              CPU_AW   = 20,
    parameter logic [CPU_AW-1:0] WIN_BASE = 20'hB8000,
    parameter logic [CPU_AW-1:0] SYS_BASE = 20'h00000
)(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [PAGE_W-1:0] win_page,
    output logic              hit,
    output logic [PHYS_W-1:0] phys
);
    localparam logic [CPU_AW-OFFS_W-1:0] WIN_TAG = WIN_BASE[CPU_AW-1:OFFS_W];
    localparam logic [CPU_AW-PHYS_W-1:0] SYS_TAG = SYS_BASE[CPU_AW-1:PHYS_W];

    logic win_hit;
    logic sys_hit;

    // Compare the upper address bits against both regions.
    always_comb begin
        win_hit = (cpu_addr[CPU_AW-1:OFFS_W] == WIN_TAG);
        sys_hit = (cpu_addr[CPU_AW-1:PHYS_W] == SYS_TAG);
        hit     = win_hit || sys_hit;
    end

    // Window accesses take the page from the register; system ones do not.
    always_comb begin
        if (win_hit) phys = {win_page, cpu_addr[OFFS_W-1:0]};
        else         phys = cpu_addr[PHYS_W-1:0];
    end
endmodule

// File: rtl/vmag_vid_map.sv
// Display address mapping: puts page bits above the controller's word
// address. In wide mode the controller's top bit replaces the page LSB.
// Assumes PAGE_W >= 2 and that a word is 16 bits (one page = 16K words).
module vmag_vid_map
    import vmag_pkg::*;
#(
    parameter int VAW = OFFS_W
)(
    input  logic [VAW-1:0]    vid_addr,
    input  logic [PAGE_W-1:0] vid_page,
    input  logic              wide,
    output logic [PHYS_W-2:0] word
);
    // Select the narrow (one page) or wide (two page) form.
    always_comb begin
        if (wide) word = {vid_page[PAGE_W-1:1], vid_addr};
        else      word = {vid_page, vid_addr[VAW-2:0]};
    end
endmodule

// File: rtl/vmag_dram_mux.sv
// DRAM pin stage: picks CPU or display word, then the row or column half,
// and registers the address, request and bank select for the pins.
// Assumes col_sel is driven by the access sequencer one cycle after row.
module vmag_dram_mux #(
    parameter int RC_W = 8
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vid_cycle,
    input  logic            col_sel,
    input  logic            cpu_hit,
    input  logic [2*RC_W:0] cpu_phys,
    input  logic [2*RC_W-1:0] vid_word,
    output logic [RC_W-1:0] dram_addr,
    output logic            dram_req,
    output logic            dram_bank
);
    logic [2*RC_W-1:0] word;
    logic              bank;

    // Source select: the display has priority over the CPU.
    always_comb begin
        if (vid_cycle) begin
            word = vid_word;
            bank = 1'b0;
        end else begin
            word = cpu_phys[2*RC_W:1];
            bank = cpu_phys[0];
        end
    end

    // Register the row or column half and the request toward the DRAM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_addr <= '0;
            dram_req  <= 1'b0;
            dram_bank <= 1'b0;
        end else begin
            dram_addr <= col_sel ? word[2*RC_W-1:RC_W] : word[RC_W-1:0];
            dram_req  <= vid_cycle || cpu_hit;
            dram_bank <= bank;
        end
    end
endmodule

// File: rtl/vmag_top.sv
// Paged shared video memory address generator (top).
// Maps a CPU byte address or a display word address onto a 128 KB DRAM
// made of two byte banks, and drives the multiplexed row/column address.
// Assumes inputs are stable over each clock cycle.
module vmag_top
    import vmag_pkg::*;
#(
    parameter int                CPU_AW   = 20,
    parameter int                VAW      = OFFS_W,
    parameter logic [CPU_AW-1:0] WIN_BASE = 20'hB8000,
    parameter logic [CPU_AW-1:0] SYS_BASE = 20'h00000
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [7:0]                reg_wdata,
    input  logic [CPU_AW-1:0]         cpu_addr,
    input  logic [VAW-1:0]            vid_addr,
    input  logic                      vid_cycle,
    input  logic                      col_sel,
    output logic                      cpu_hit,
    output logic                      dram_req,
    output logic [(PHYS_W-1)/2-1:0]   dram_addr,
    output logic                      dram_bank
);
    localparam int RC_W = (PHYS_W - 1) / 2;

    page_reg_t         page_q;
    logic [PAGE_W-1:0] win_page;
    logic [PHYS_W-1:0] cpu_phys;
    logic [PHYS_W-2:0] vid_word;

    vmag_page_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .wdata (page_reg_t'(reg_wdata)),
        .q     (page_q)
    );

    // The window page follows the display page when bit 6 is set.
    always_comb win_page = page_q.win_follow ? page_q.vid_page : page_q.cpu_page;

    vmag_cpu_decode #(
        .CPU_AW   (CPU_AW),
        .WIN_BASE (WIN_BASE),
        .SYS_BASE (SYS_BASE)
    ) u_dec (
        .cpu_addr (cpu_addr),
        .win_page (win_page),
        .hit      (cpu_hit),
        .phys     (cpu_phys)
    );

    vmag_vid_map #(.VAW(VAW)) u_vid (
        .vid_addr (vid_addr),
        .vid_page (page_q.vid_page),
        .wide     (page_q.wide),
        .word     (vid_word)
    );

    vmag_dram_mux #(.RC_W(RC_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .vid_cycle (vid_cycle),
        .col_sel   (col_sel),
        .cpu_hit   (cpu_hit),
        .cpu_phys  (cpu_phys),
        .vid_word  (vid_word),
        .dram_addr (dram_addr),
        .dram_req  (dram_req),
        .dram_bank (dram_bank)
    );
endmodule

// File: rtl/vmag_chk.sv
// Protocol checker for vmag_top, attached by bind.
// Assumes the default 20-bit CPU address and 8-bit row/column.
module vmag_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_wdata,
    input logic [19:0] cpu_addr,
    input logic [14:0] vid_addr,
    input logic        vid_cycle,
    input logic        col_sel,
    input logic        cpu_hit,
    input logic        dram_req,
    input logic [7:0]  dram_addr,
    input logic        dram_bank,
    input logic [7:0]  reg_q
);
    // R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(reg_q));

    // R2
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_q == $past(reg_wdata)));

    // R5
    no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vid_cycle && !cpu_hit) |=> !dram_req);

    // R11
    vid_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_cycle |=> (dram_req && !dram_bank));

    // R10
    vid_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_cycle && !col_sel) |=> (dram_addr == $past(vid_addr[7:0])));

    // R4
    sys_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vid_cycle && !col_sel && cpu_addr[19:17] == 3'b000)
        |=> (dram_addr == $past(cpu_addr[8:1]) && dram_bank == $past(cpu_addr[0])));
endmodule

bind vmag_top vmag_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .cpu_addr  (cpu_addr),
    .vid_addr  (vid_addr),
    .vid_cycle (vid_cycle),
    .col_sel   (col_sel),
    .cpu_hit   (cpu_hit),
    .dram_req  (dram_req),
    .dram_addr (dram_addr),
    .dram_bank (dram_bank),
    .reg_q     (page_q)
);

// File: tb/vmag_top_tb_top.sv
`timescale 1ns/1ps
module vmag_top_tb_top;
    localparam time CLK_P = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [19:0] cpu_addr = '0;
    logic [14:0] vid_addr = '0;
    logic        vid_cycle = 1'b0;
    logic        col_sel = 1'b0;
    logic        cpu_hit;
    logic        dram_req;
    logic [7:0]  dram_addr;
    logic        dram_bank;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_reg = '0;

    always #(CLK_P/2) clk = ~clk;

    vmag_top dut_i (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
        .cpu_addr (cpu_addr), .vid_addr (vid_addr), .vid_cycle (vid_cycle),
        .col_sel (col_sel), .cpu_hit (cpu_hit), .dram_req (dram_req),
        .dram_addr (dram_addr), .dram_bank (dram_bank)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic win_of(logic [19:0] ca);
        return ca[19:15] == 5'h17;
    endfunction

    function automatic logic sys_of(logic [19:0] ca);
        return ca[19:17] == 3'b000;
    endfunction

    // Reference physical byte address for a CPU access.
    function automatic logic [16:0] m_phys(logic [19:0] ca, logic [7:0] r);
        logic [1:0] pg = r[6] ? r[3:2] : r[1:0];
        if (win_of(ca)) return {pg, ca[14:0]};
        return ca[16:0];
    endfunction

    // Reference 16-bit DRAM word address.
    function automatic logic [15:0] m_word(logic vid, logic [19:0] ca,
                                           logic [14:0] va, logic [7:0] r);
        logic [16:0] p;
        if (vid) return r[7] ? {r[3], va} : {r[3:2], va[13:0]};
        p = m_phys(ca, r);
        return p[16:1];
    endfunction

    // Drive one cycle at a falling edge and check at the next falling edge.
    task automatic step(logic vid, logic cs, logic [19:0] ca, logic [14:0] va, string note);
        logic        e_hit;
        logic        e_req;
        logic [15:0] w;
        logic [16:0] p;
        string       tg;
        vid_cycle = vid; col_sel = cs; cpu_addr = ca; vid_addr = va;
        e_hit = win_of(ca) || sys_of(ca);
        e_req = vid || e_hit;
        w     = m_word(vid, ca, va, m_reg);
        p     = m_phys(ca, m_reg);
        if (vid)             tg = m_reg[7] ? "R7" : "R6";
        else if (win_of(ca)) tg = m_reg[6] ? "R8" : "R3";
        else if (sys_of(ca)) tg = "R4";
        else                 tg = "R5";
        @(negedge clk);
        check({tg, " hit ", note}, 32'(cpu_hit), 32'(e_hit));
        check({vid ? "R11" : "R5", " req ", note}, 32'(dram_req), 32'(e_req));
        if (e_req) begin
            check({tg, " R10 addr ", note}, 32'(dram_addr), 32'(cs ? w[15:8] : w[7:0]));
            check({"R9 bank ", note}, 32'(dram_bank), 32'(vid ? 1'b0 : p[0]));
        end
    endtask

    task automatic wr(logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        m_reg = v;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: values during reset
        cpu_addr = 20'hB9234; vid_cycle = 1'b1; vid_addr = 15'h1234;
        repeat (3) @(negedge clk);
        check("R1 req in reset", 32'(dram_req), 32'd0);
        check("R1 addr in reset", 32'(dram_addr), 32'd0);
        check("R1 bank in reset", 32'(dram_bank), 32'd0);
        rst_n = 1'b1;
        // R1: page zero after reset
        step(1'b0, 1'b0, 20'hB9235, 15'h0, "R1 window");
        step(1'b0, 1'b1, 20'hBFFFF, 15'h0, "R1 window col");
        step(1'b1, 1'b1, 20'h00000, 15'h7FFF, "R1 video");

        // R2/R3: write then window access
        wr(8'h02);
        step(1'b0, 1'b1, 20'hB8000, 15'h0, "R2 new page");
        // R2: spare bits have no effect
        wr(8'h32);
        step(1'b0, 1'b1, 20'hBC001, 15'h0, "R2 spare");
        step(1'b1, 1'b1, 20'hBC001, 15'h4ABC, "R2 spare video");

        // R3/R4/R5: region edges
        step(1'b0, 1'b0, 20'hB7FFF, 15'h0, "R5 below window");
        step(1'b0, 1'b1, 20'hB8000, 15'h0, "R3 window low");
        step(1'b0, 1'b1, 20'hBFFFF, 15'h0, "R3 window high");
        step(1'b0, 1'b0, 20'hC0000, 15'h0, "R5 above window");
        step(1'b0, 1'b1, 20'h1FFFF, 15'h0, "R4 sys top");
        step(1'b0, 1'b0, 20'h20000, 15'h0, "R5 above sys");

        // Every register value: window, system and display, row and column.
        for (int v = 0; v < 256; v++) begin
            wr(8'(v));
            step(1'b0, 1'b0, 20'hBA5A5, 15'h0, "page sweep R3 row");
            step(1'b0, 1'b1, 20'hBA5A5, 15'h0, "page sweep R3 col");
            step(1'b0, 1'b1, 20'h1C3C3, 15'h0, "page sweep R4");
            step(1'b1, 1'b1, 20'hBA5A5, 15'h6123, "page sweep R6 R7 R11");
            step(1'b1, 1'b1, 20'h55555, 15'h2123, "page sweep R6 bit14");
        end

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] ca;
            int          k = $urandom % 3;
            if (($urandom % 16) == 0) wr(8'($urandom));
            if (k == 0)      ca = 20'hB8000 | 20'($urandom % 32768);
            else if (k == 1) ca = 20'($urandom % 131072);
            else             ca = 20'h20000 + 20'($urandom % 20'h98000);
            if (($urandom % 8) == 0) ca = 20'hC0000 | 20'($urandom % 20'h40000);
            step(1'($urandom), 1'($urandom), ca, 15'($urandom), "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule